// File: doc/BRIEF.md
# Ethernet Frame Hardware Timestamp Unit

This block sits beside one Ethernet port and watches the 4-bit receive and transmit nibble streams of the media-independent interface. It keeps a free-running nanosecond counter. When a frame event is seen in either direction, it copies that counter into a holding register for that direction. Because the copy is taken by hardware in the cycle of the event, the stamp carries none of the interrupt and software latency that comes with reading a timer from code.

A mode input selects the event that triggers the capture. In the first mode the capture happens on the first nibble of a frame, where the preamble begins. In the second mode it happens on the start-frame-delimiter nibble, which follows the run of preamble nibbles. Each direction has its own stamp, a valid flag and an overflow flag. The host reads a stamp by pulsing that direction's read strobe.

The counter adds a loadable step on every clock. The step defaults to 40 ns, which is one nibble period at 25 MHz. The host can also load the counter with an absolute value.

Top module: `frame_tstamp_unit`

## Requirements
- R1: After reset the counter reads 0, the step is DEF_INC (40), and both stamps, valid flags and overflow flags read 0.
- R2: On each clock where no load is requested, the counter advances by the current step, modulo 2^TS_W. A step written with `inc_wr` is used from the following clock onward.
- R3: `tmr_wr` loads `tmr_val` into the counter at the next edge, and a load takes priority over the increment.
- R4: With `sfd_mode`=0, the stamp of a direction takes the counter value seen in the first cycle in which that direction's enable is high after having been low.
- R5: With `sfd_mode`=1, the stamp takes the counter value seen in the cycle that carries nibble 0xD directly after a nibble 0x5, both with the enable high. Nibbles before the first 0x5 are skipped.
- R6: In `sfd_mode`=1, only the first delimiter of a frame triggers a capture. Later 0x5 then 0xD pairs in the payload are ignored until the enable has gone low.
- R7: Receive and transmit are detected and stamped independently, including when their frames overlap.
- R8: A capture that arrives while the stamp is still valid and not being read sets the overflow flag and keeps the older stamp.
- R9: A read strobe clears the valid flag and the overflow flag at the next edge and leaves the stamp unchanged. A read with nothing valid has no other effect.
- R10: When a read and a capture fall in the same cycle, the new value is stored, the valid flag stays set and the overflow flag is cleared.
- R11: The stamp and counter width is the parameter TS_W (32 or 64, default 64), and the counter wraps through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfd_mode | input | 1 | 0: capture at preamble start, 1: capture at delimiter |
| inc_wr | input | 1 | Load strobe for the step |
| inc_val | input | INC_W | New step in ns |
| tmr_wr | input | 1 | Load strobe for the counter |
| tmr_val | input | TS_W | New counter value |
| tmr_now | output | TS_W | Current counter value |
| rx_dv | input | 1 | Receive data valid |
| rx_d | input | 4 | Receive nibble |
| tx_en | input | 1 | Transmit enable |
| tx_d | input | 4 | Transmit nibble |
| rx_rd | input | 1 | Read strobe for the receive stamp |
| rx_ts | output | TS_W | Receive stamp |
| rx_vld | output | 1 | Receive stamp valid |
| rx_ovf | output | 1 | Receive capture lost |
| tx_rd | input | 1 | Read strobe for the transmit stamp |
| tx_ts | output | TS_W | Transmit stamp |
| tx_vld | output | 1 | Transmit stamp valid |
| tx_ovf | output | 1 | Transmit capture lost |

## Verification
Within one direction, a host read and a new capture can fall on the same clock. The result then depends on which of the two takes priority over the valid and overflow flags. The bench holds a stamp valid and raises the read strobe on the exact cycle in which a frame's first nibble appears. It also provokes the same collision without the read, which must give an overflow and keep the old stamp. A behavioural model predicts the flags and the stamp, and the design is compared against it on every clock.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam logic [3:0] PRE_NIB = 4'h5;
    localparam logic [3:0] DLM_NIB = 4'hD;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_GOT5  = 2'd1,
        ST_FOUND = 2'd2
    } dlm_st_e;
endpackage

// File: rtl/tsu_timer.sv
module tsu_timer #(
    parameter int TS_W    = 64,
    parameter int INC_W   = 8,
    parameter int DEF_INC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_wr,
    input  logic [INC_W-1:0] inc_val,
    input  logic             tmr_wr,
    input  logic [TS_W-1:0]  tmr_val,
    output logic [TS_W-1:0]  tmr_now,
    output logic [INC_W-1:0] inc_cur
);
    typedef struct packed {
        logic [TS_W-1:0]  tmr;
        logic [INC_W-1:0] inc;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tmr_wr) st_d.tmr = tmr_val;
        else        st_d.tmr = st_q.tmr + TS_W'(st_q.inc);
        if (inc_wr) st_d.inc = inc_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tmr <= '0;
            st_q.inc <= INC_W'(DEF_INC);
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_now = st_q.tmr;
    assign inc_cur = st_q.inc;
endmodule

// File: rtl/tsu_frame_detect.sv
module tsu_frame_detect
    import tsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sfd_mode,
    input  logic       en,
    input  logic [3:0] nib,
    output logic       evt
);
    typedef struct packed {
        logic    prev_en;
        dlm_st_e st;
    } det_s;

    det_s det_d, det_q;
    logic sof_hit, dlm_hit;

    always_comb begin
        sof_hit = en && !det_q.prev_en;
        dlm_hit = en && (det_q.st == ST_GOT5) && (nib == DLM_NIB);
        evt     = sfd_mode ? dlm_hit : sof_hit;

        det_d         = det_q;
        det_d.prev_en = en;
        if (!en) begin
            det_d.st = ST_HUNT;
        end else begin
            unique case (det_q.st)
                ST_HUNT: if (nib == PRE_NIB) det_d.st = ST_GOT5;
                ST_GOT5: begin
                    if (nib == DLM_NIB)      det_d.st = ST_FOUND;
                    else if (nib != PRE_NIB) det_d.st = ST_HUNT;
                end
                ST_FOUND: det_d.st = ST_FOUND;
                default:  det_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q.prev_en <= 1'b0;
            det_q.st      <= ST_HUNT;
        end else begin
            det_q <= det_d;
        end
    end
endmodule

// File: rtl/tsu_capture_reg.sv
module tsu_capture_reg #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt,
    input  logic            rd,
    input  logic [TS_W-1:0] now,
    output logic [TS_W-1:0] ts,
    output logic            vld,
    output logic            ovf
);
    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic            vld;
        logic            ovf;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rd) begin
            cap_d.vld = 1'b0;
            cap_d.ovf = 1'b0;
        end
        if (evt) begin
            if (!cap_q.vld || rd) begin
                cap_d.ts  = now;
                cap_d.vld = 1'b1;
            end else begin
                cap_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign ts  = cap_q.ts;
    assign vld = cap_q.vld;
    assign ovf = cap_q.ovf;
endmodule

// File: rtl/frame_tstamp_unit.sv
module frame_tstamp_unit #(
    parameter int TS_W    = 64,
    parameter int INC_W   = 8,
    parameter int DEF_INC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sfd_mode,
    input  logic             inc_wr,
    input  logic [INC_W-1:0] inc_val,
    input  logic             tmr_wr,
    input  logic [TS_W-1:0]  tmr_val,
    output logic [TS_W-1:0]  tmr_now,
    input  logic             rx_dv,
    input  logic [3:0]       rx_d,
    input  logic             tx_en,
    input  logic [3:0]       tx_d,
    input  logic             rx_rd,
    output logic [TS_W-1:0]  rx_ts,
    output logic             rx_vld,
    output logic             rx_ovf,
    input  logic             tx_rd,
    output logic [TS_W-1:0]  tx_ts,
    output logic             tx_vld,
    output logic             tx_ovf
);
    localparam int N_DIR = 2;

    logic [INC_W-1:0] inc_cur;
    logic [N_DIR-1:0] en_a, rd_a, evt_a, vld_a, ovf_a;
    logic [3:0]       nib_a [N_DIR];
    logic [TS_W-1:0]  ts_a  [N_DIR];

    assign en_a     = {tx_en, rx_dv};
    assign rd_a     = {tx_rd, rx_rd};
    assign nib_a[0] = rx_d;
    assign nib_a[1] = tx_d;

    tsu_timer #(.TS_W(TS_W), .INC_W(INC_W), .DEF_INC(DEF_INC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_wr  (inc_wr),
        .inc_val (inc_val),
        .tmr_wr  (tmr_wr),
        .tmr_val (tmr_val),
        .tmr_now (tmr_now),
        .inc_cur (inc_cur)
    );

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        tsu_frame_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sfd_mode (sfd_mode),
            .en       (en_a[g]),
            .nib      (nib_a[g]),
            .evt      (evt_a[g])
        );
        tsu_capture_reg #(.TS_W(TS_W)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_a[g]),
            .rd    (rd_a[g]),
            .now   (tmr_now),
            .ts    (ts_a[g]),
            .vld   (vld_a[g]),
            .ovf   (ovf_a[g])
        );
    end

    assign rx_ts  = ts_a[0];
    assign rx_vld = vld_a[0];
    assign rx_ovf = ovf_a[0];
    assign tx_ts  = ts_a[1];
    assign tx_vld = vld_a[1];
    assign tx_ovf = ovf_a[1];
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
    parameter int TS_W  = 64,
    parameter int INC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_wr,
    input logic [TS_W-1:0]  tmr_val,
    input logic [TS_W-1:0]  tmr_now,
    input logic [INC_W-1:0] inc_cur,
    input logic             rx_evt,
    input logic             rx_rd,
    input logic [TS_W-1:0]  rx_ts,
    input logic             rx_vld,
    input logic             rx_ovf,
    input logic             tx_evt,
    input logic             tx_rd,
    input logic [TS_W-1:0]  tx_ts,
    input logic             tx_vld,
    input logic             tx_ovf
);
    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> tmr_now == $past(tmr_val)); // R3
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> tmr_now == TS_W'($past(tmr_now) + TS_W'($past(inc_cur)))); // R2
    AST_RX_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && rx_vld && !rx_rd |=> rx_ovf && $stable(rx_ts)); // R8
    AST_TX_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && tx_vld && !tx_rd |=> tx_ovf && $stable(tx_ts)); // R8
    AST_RX_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd && !rx_evt |=> !rx_vld && !rx_ovf && $stable(rx_ts)); // R9
    AST_TX_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd && !tx_evt |=> !tx_vld && !tx_ovf && $stable(tx_ts)); // R9
    AST_RX_TAKE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && (!rx_vld || rx_rd) |=> rx_vld && !rx_ovf && rx_ts == $past(tmr_now)); // R10
    AST_TX_TAKE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt && (!tx_vld || tx_rd) |=> tx_vld && !tx_ovf && tx_ts == $past(tmr_now)); // R10
    AST_RX_VLD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_vld) |-> $past(rx_evt)); // R4
    AST_TX_VLD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_vld) |-> $past(tx_evt)); // R7
endmodule

bind frame_tstamp_unit tsu_checker #(.TS_W(TS_W), .INC_W(INC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_wr  (tmr_wr),
    .tmr_val (tmr_val),
    .tmr_now (tmr_now),
    .inc_cur (inc_cur),
    .rx_evt  (evt_a[0]),
    .rx_rd   (rx_rd),
    .rx_ts   (rx_ts),
    .rx_vld  (rx_vld),
    .rx_ovf  (rx_ovf),
    .tx_evt  (evt_a[1]),
    .tx_rd   (tx_rd),
    .tx_ts   (tx_ts),
    .tx_vld  (tx_vld),
    .tx_ovf  (tx_ovf)
);

// File: tb/frame_tstamp_unit_test.sv
module frame_tstamp_unit_test;
    localparam int TCLK  = 10;
    localparam int TS_W  = 64;
    localparam int INC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sfd_mode = 1'b0;
    logic             inc_wr = 1'b0;
    logic [INC_W-1:0] inc_val = '0;
    logic             tmr_wr = 1'b0;
    logic [TS_W-1:0]  tmr_val = '0;
    logic [TS_W-1:0]  tmr_now;
    logic             rx_dv = 1'b0, tx_en = 1'b0;
    logic [3:0]       rx_d = '0, tx_d = '0;
    logic             rx_rd = 1'b0, tx_rd = 1'b0;
    logic [TS_W-1:0]  rx_ts, tx_ts;
    logic             rx_vld, rx_ovf, tx_vld, tx_ovf;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur = "R1";

    frame_tstamp_unit #(.TS_W(TS_W), .INC_W(INC_W), .DEF_INC(40)) uut (
        .clk(clk), .rst_n(rst_n), .sfd_mode(sfd_mode),
        .inc_wr(inc_wr), .inc_val(inc_val), .tmr_wr(tmr_wr), .tmr_val(tmr_val),
        .tmr_now(tmr_now), .rx_dv(rx_dv), .rx_d(rx_d), .tx_en(tx_en), .tx_d(tx_d),
        .rx_rd(rx_rd), .rx_ts(rx_ts), .rx_vld(rx_vld), .rx_ovf(rx_ovf),
        .tx_rd(tx_rd), .tx_ts(tx_ts), .tx_vld(tx_vld), .tx_ovf(tx_ovf)
    );

    always #(TCLK/2) clk = ~clk;

    // behavioural reference model
    logic [TS_W-1:0] m_tmr;
    int              m_inc;
    logic [TS_W-1:0] m_ts   [2];
    bit              m_vld  [2];
    bit              m_ovf  [2];
    bit              m_prev [2];
    int              m_hunt [2];   // 0 searching, 1 saw 0x5, 2 delimiter done

    always @(posedge clk) begin
        bit        en [2];
        bit        rd [2];
        bit        ev;
        bit        fire;
        bit        shift;
        logic [3:0] nb [2];
        en[0] = rx_dv; en[1] = tx_en; nb[0] = rx_d; nb[1] = tx_d;
        rd[0] = rx_rd; rd[1] = tx_rd;
        if (!rst_n) begin
            m_tmr = '0; m_inc = 40;
            for (int k = 0; k < 2; k++) begin
                m_ts[k] = '0; m_vld[k] = 0; m_ovf[k] = 0; m_prev[k] = 0; m_hunt[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (sfd_mode) ev = en[k] && m_hunt[k] == 1 && nb[k] == 4'hD;
                else          ev = en[k] && !m_prev[k];
                fire = ev && (!m_vld[k] || rd[k]);
                if (rd[k]) begin m_vld[k] = 0; m_ovf[k] = 0; end
                if (fire) begin m_ts[k] = m_tmr; m_vld[k] = 1; end
                else if (ev) m_ovf[k] = 1;
                if (!en[k]) m_hunt[k] = 0;
                else if (m_hunt[k] == 0 && nb[k] == 4'h5) m_hunt[k] = 1;
                else if (m_hunt[k] == 1 && nb[k] == 4'hD) m_hunt[k] = 2;
                else if (m_hunt[k] == 1 && nb[k] != 4'h5) m_hunt[k] = 0;
                m_prev[k] = en[k];
            end
            shift = tmr_wr;
            if (shift) m_tmr = tmr_val;
            else       m_tmr = m_tmr + TS_W'(m_inc);
            if (inc_wr) m_inc = int'(inc_val);
        end
    end

    task automatic chk_f(string what, logic [TS_W-1:0] act, logic [TS_W-1:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        n_vec++;
        chk_f("tmr_now", tmr_now, m_tmr);
        chk_f("rx_ts",   rx_ts,   m_ts[0]);
        chk_f("rx_vld",  TS_W'(rx_vld), TS_W'(m_vld[0]));
        chk_f("rx_ovf",  TS_W'(rx_ovf), TS_W'(m_ovf[0]));
        chk_f("tx_ts",   tx_ts,   m_ts[1]);
        chk_f("tx_vld",  TS_W'(tx_vld), TS_W'(m_vld[1]));
        chk_f("tx_ovf",  TS_W'(tx_ovf), TS_W'(m_ovf[1]));
    endtask

    task automatic cyc(bit re, logic [3:0] rn, bit te, logic [3:0] tn, bit rr, bit tr);
        rx_dv = re; rx_d = rn; tx_en = te; tx_d = tn; rx_rd = rr; tx_rd = tr;
        step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 4'h0, 0, 4'h0, 0, 0);
    endtask

    function automatic logic [3:0] nib_at(int i, int npre);
        if (i < npre)  return 4'h5;
        if (i == npre) return 4'hD;
        case ((i - npre) % 3)
            0:       return 4'h5;
            1:       return 4'hD;
            default: return 4'hA;
        endcase
    endfunction

    // frames on both directions with cycle offsets; a disabled direction stays idle
    task automatic frames(bit ron, bit ton, int roff, int toff, int len, int npre);
        int last = ((roff > toff) ? roff : toff) + len + 3;
        for (int t = 0; t < last; t++) begin
            bit re = ron && t >= roff && t < roff + len;
            bit te = ton && t >= toff && t < toff + len;
            cyc(re, re ? nib_at(t - roff, npre) : 4'h0,
                te, te ? nib_at(t - toff, npre) : 4'h0, 0, 0);
        end
    endtask

    initial begin
        // R1: reset values
        cur = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(3);

        // R2: stepping and step reload
        cur = "R2";
        idle(4);
        inc_wr = 1; inc_val = 8'd8; idle(1); inc_wr = 0;
        idle(4);

        // R3: counter load wins over increment
        cur = "R3";
        tmr_wr = 1; tmr_val = 64'd1000; idle(1); tmr_wr = 0;
        idle(3);

        // R4: capture on preamble start
        cur = "R4";
        sfd_mode = 0;
        frames(1, 0, 0, 0, 12, 7);
        cyc(0, 0, 0, 0, 1, 0);
        idle(2);

        // R5: delimiter capture with leading noise nibbles
        cur = "R5";
        sfd_mode = 1;
        cyc(1, 4'h3, 0, 0, 0, 0);
        cyc(1, 4'hD, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) cyc(1, nib_at(i, 5), 0, 0, 0, 0);
        idle(2);

        // R6: read right after delimiter, payload 5,D pairs must not recapture
        cur = "R6";
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 6; i++) cyc(1, nib_at(i, 4), 0, 0, i == 5, 0);
        for (int i = 6; i < 16; i++) cyc(1, nib_at(i, 4), 0, 0, 0, 0);
        idle(2);

        // R7: overlapping rx and tx frames, both modes
        cur = "R7";
        cyc(0, 0, 0, 0, 1, 1);
        frames(1, 1, 0, 3, 14, 7);
        cyc(0, 0, 0, 0, 1, 1);
        sfd_mode = 0;
        frames(1, 1, 4, 1, 10, 5);
        cyc(0, 0, 0, 0, 1, 1);
        idle(1);

        // R8: second frame with stamp unread
        cur = "R8";
        frames(1, 0, 0, 0, 6, 3);
        frames(1, 1, 0, 0, 6, 3);
        frames(0, 1, 0, 0, 6, 3);

        // R9: read clears both flags, empty read is harmless
        cur = "R9";
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 1, 1);
        idle(2);

        // R10: read on the very cycle of a capture
        cur = "R10";
        frames(1, 1, 0, 0, 5, 3);
        cyc(1, 4'h5, 1, 4'h5, 1, 1);
        for (int i = 1; i < 6; i++) cyc(1, 4'h5, 1, 4'h5, 0, 0);
        idle(2);
        cyc(0, 0, 0, 0, 1, 1);

        // R11: wrap of the 64-bit counter through zero
        cur = "R11";
        tmr_wr = 1; tmr_val = 64'hFFFF_FFFF_FFFF_FFE0; idle(1); tmr_wr = 0;
        frames(1, 0, 2, 0, 6, 3);
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(TCLK * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule